// File: doc/BRIEF.md
# External Bus Cycle Timing Generator

This block produces the strobe waveforms for a single external memory area. A requester presents an access (address, direction, access size, write data and an optional number of extra burst beats) together with configuration fields: device type, bus width, wait code and setup/hold codes. If the address decodes to this area, the block captures the access and its configuration, then runs an address-setup phase, a strobe phase split into one or more beats, and a hold phase. It finishes with a one-cycle completion pulse.

The area can be attached to one of two device styles. With ordinary static memory or burst ROM, a chip select frames the cycle, a read strobe serves as output enable, and four byte-lane write enables carry writes. With a PC-card style device, two card enables (low and high byte) replace the chip select. In that style the lower 32 MB half of the area holds card memory, which uses the read strobe and a single write strobe, and the upper half holds card I/O, which uses dedicated I/O read and I/O write strobes.

The block runs on a clock at twice the bus rate, so one clock is a half bus cycle (a "tick"). Setup and hold are therefore programmable in half-cycle steps. An active-low external wait input, sampled only at the last tick of each beat, can stretch the access without limit.

Top module: `ext_bus_timer`

## Requirements
- R1: An access is accepted only when address bits 28..26 equal the area number (default 6). Bits 31..29 are ignored. A request to any other area leaves the block idle with every strobe inactive.
- R2: In memory mode (card select 0), cs_n_o is low from the first setup tick to the last hold tick. During the strobe phase, rd_n_o is low for reads and the write enables of the active lanes are low for writes.
- R3: Active byte lanes are computed as follows. The effective width is min(bus width code, 2) in memory mode and min(code, 1) in card mode (0 = 8, 1 = 16, 2 = 32 bits). The effective size is min(size code, effective width) (0 byte, 1 word, 2 long), giving n = 2^size bytes. The lanes are n consecutive lanes starting at (address mod 2^width) rounded down to a multiple of n. we_n_o bit i belongs to lane i.
- R4: In card mode cs_n_o stays high. ce1_n_o is low throughout the access when lane 0 is active, and ce2_n_o is low when lane 1 is active.
- R5: In card mode, address bit 25 = 0 selects card memory: rd_n_o is used for reads and only we_n_o[0] for writes. Bit 25 = 1 selects card I/O: iord_n_o is used for reads and iowr_n_o for writes, while rd_n_o and we_n_o stay high.
- R6: In memory mode, wait code bits 2..0 map to W = {0,1,2,3,4,6,8,10}, and code bit 3 is ignored. The first beat's strobe lasts 2(W+1) ticks when no external wait is applied.
- R7: In card mode, the 4-bit wait code maps to W = {0,1,2,3,4,6,8,10,12,14,18,22,26,30,34,38}, with the same 2(W+1)-tick first beat.
- R8: Setup code s gives 2s+1 ticks of select before the strobe. Hold code h gives 2h+1 ticks of select after it.
- R9: wait_n_i is sampled only in the last tick of a beat. Each low sample there adds one tick. A low level in any other tick has no effect.
- R10: An access carries extra_beats_i further beats. Each further beat lasts 2·max(2, W+1) ticks with the strobe held. The address advances by 2^size bytes (effective size) between beats. After each beat, beat_o pulses for one tick and rdata_o holds the bus data sampled in that beat's last tick.
- R11: After the last hold tick, done_o pulses for one tick and busy_o falls. While busy, new requests and changes on the configuration inputs have no effect. After reset the block is idle, with every strobe high and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, one period per half bus cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, taken when idle |
| addr_i | input | 32 | Access address |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 0 byte, 1 word, 2/3 long |
| wdata_i | input | 32 | Write data |
| extra_beats_i | input | BEAT_W | Number of beats after the first |
| card_mode_i | input | 1 | 1 = PC-card style strobes, 0 = memory style |
| bus_width_i | input | 2 | Bus width code |
| wait_code_i | input | 4 | Programmed wait code |
| setup_code_i | input | 3 | Setup code s (2s+1 ticks) |
| hold_code_i | input | 3 | Hold code h (2h+1 ticks) |
| wait_n_i | input | 1 | External wait request, active low |
| rdata_bus_i | input | 32 | Data returned by the device |
| busy_o | output | 1 | Access in progress |
| beat_o | output | 1 | One-tick pulse after each beat |
| done_o | output | 1 | One-tick pulse at completion |
| rdata_o | output | 32 | Data captured at the last beat end |
| addr_o | output | 32 | Current beat address |
| wdata_o | output | 32 | Captured write data |
| cs_n_o | output | 1 | Area chip select, memory mode |
| ce1_n_o | output | 1 | Card enable, low byte |
| ce2_n_o | output | 1 | Card enable, high byte |
| rd_n_o | output | 1 | Read strobe / output enable |
| we_n_o | output | 4 | Per-lane write enables |
| iord_n_o | output | 1 | Card I/O read strobe |
| iowr_n_o | output | 1 | Card I/O write strobe |

## Verification
The bench builds the block with its default parameters: area 6, a 2-bit beat count (up to three extra beats) and card support present. These settings cover both strobe sets, the full 16-entry card wait table up to 38 waits, and bursts long enough to see the byte-access lane alternation in card mode and the address stepping. A behavioural model turns each access into a per-tick list of expected strobe levels and compares every tick. In some runs that model drives the wait input low in ticks where it must not count, and scrambles the live configuration while an access is running.

// File: rtl/xbt_pkg.sv
package xbt_pkg;

   localparam int unsigned WAIT_W   = 6;
   localparam int unsigned MAX_WAIT = 38;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_t;

   // memory-style wait table, 3-bit code
   function automatic logic [WAIT_W-1:0] mem_waits(input logic [2:0] code);
      case (code)
         3'd5:    return WAIT_W'(6);
         3'd6:    return WAIT_W'(8);
         3'd7:    return WAIT_W'(10);
         default: return WAIT_W'(code);
      endcase
   endfunction

   // card-style wait table, 4-bit code
   function automatic logic [WAIT_W-1:0] card_waits(input logic [3:0] code);
      case (code)
         4'd5:    return WAIT_W'(6);
         4'd6:    return WAIT_W'(8);
         4'd7:    return WAIT_W'(10);
         4'd8:    return WAIT_W'(12);
         4'd9:    return WAIT_W'(14);
         4'd10:   return WAIT_W'(18);
         4'd11:   return WAIT_W'(22);
         4'd12:   return WAIT_W'(26);
         4'd13:   return WAIT_W'(30);
         4'd14:   return WAIT_W'(34);
         4'd15:   return WAIT_W'(38);
         default: return WAIT_W'(code);
      endcase
   endfunction

endpackage

// File: rtl/xbt_wait_map.sv
module xbt_wait_map
   import xbt_pkg::*;
#(
   parameter bit HAS_PCCARD = 1'b1
) (
   input  logic              card,
   input  logic [3:0]        code,
   output logic [WAIT_W-1:0] waits
);

   generate
      if (HAS_PCCARD) begin : g_card
         assign waits = card ? card_waits(code) : mem_waits(code[2:0]);
      end else begin : g_mem
         logic unused_bits;
         assign unused_bits = card ^ code[3];
         assign waits = mem_waits(code[2:0]);
      end
   endgenerate

endmodule

// File: rtl/xbt_lane_map.sv
module xbt_lane_map (
   input  logic       card,
   input  logic [1:0] width,
   input  logic [1:0] size,
   input  logic [1:0] addr_lo,
   output logic [3:0] lanes,
   output logic [2:0] step
);

   logic [1:0] eff_w, eff_s, w_mask, s_mask, off;

   always_comb begin
      if (card) eff_w = (width >= 2'd1) ? 2'd1 : 2'd0;
      else      eff_w = (width >= 2'd2) ? 2'd2 : width;
      eff_s  = (size > eff_w) ? eff_w : size;
      w_mask = (eff_w == 2'd2) ? 2'b11 : (eff_w == 2'd1) ? 2'b01 : 2'b00;
      s_mask = (eff_s == 2'd2) ? 2'b11 : (eff_s == 2'd1) ? 2'b01 : 2'b00;
      off    = addr_lo & w_mask & ~s_mask;
      case (eff_s)
         2'd2:    begin lanes = 4'hF;          step = 3'd4; end
         2'd1:    begin lanes = 4'h3 << off;   step = 3'd2; end
         default: begin lanes = 4'h1 << off;   step = 3'd1; end
      endcase
   end

endmodule

// File: rtl/xbt_seq.sv
module xbt_seq
   import xbt_pkg::*;
#(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        setup_live,
   input  logic [BEAT_W-1:0] beats_live,
   input  logic [2:0]        hold_code,
   input  logic [WAIT_W-1:0] waits,
   input  logic              wait_n,
   output phase_t            phase,
   output logic              beat_end,
   output logic              beat_more,
   output logic              beat_pulse,
   output logic              done_pulse
);

   localparam int unsigned CNT_W = $clog2(2 * (MAX_WAIT + 1));

   logic [CNT_W-1:0]  cnt, first_len, beat_len;
   logic [BEAT_W-1:0] beats_left;
   logic              last_tick;

   always_comb begin
      first_len = CNT_W'({waits, 1'b1});
      beat_len  = CNT_W'({(waits == '0) ? WAIT_W'(1) : waits, 1'b1});
      last_tick = (phase == PH_STROBE) && (cnt == '0);
      beat_end  = last_tick && wait_n;
      beat_more = beat_end && (beats_left != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cnt        <= '0;
         beats_left <= '0;
         beat_pulse <= 1'b0;
         done_pulse <= 1'b0;
      end else begin
         beat_pulse <= 1'b0;
         done_pulse <= 1'b0;
         case (phase)
            PH_IDLE: if (start) begin
               phase      <= PH_SETUP;
               cnt        <= CNT_W'({setup_live, 1'b0});
               beats_left <= beats_live;
            end
            PH_SETUP: if (cnt == '0) begin
               phase <= PH_STROBE;
               cnt   <= first_len;
            end else cnt <= cnt - 1'b1;
            PH_STROBE: if (cnt != '0) cnt <= cnt - 1'b1;
            else if (wait_n) begin
               beat_pulse <= 1'b1;
               if (beats_left != '0) begin
                  beats_left <= beats_left - 1'b1;
                  cnt        <= beat_len;
               end else begin
                  phase <= PH_HOLD;
                  cnt   <= CNT_W'({hold_code, 1'b0});
               end
            end
            PH_HOLD: if (cnt == '0) begin
               phase      <= PH_IDLE;
               done_pulse <= 1'b1;
            end else cnt <= cnt - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_WAIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (last_tick && !wait_n) |=> (phase == PH_STROBE && cnt == '0)) else $error("stall lost"); // R9
   AST_BEAT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      beat_pulse |=> !beat_pulse) else $error("beats too close"); // R10
   AST_DONE_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> ($past(phase) == PH_HOLD)) else $error("done outside hold"); // R11

endmodule

// File: rtl/ext_bus_timer.sv
module ext_bus_timer
   import xbt_pkg::*;
#(
   parameter int unsigned AREA_ID    = 6,
   parameter int unsigned BEAT_W     = 2,
   parameter bit          HAS_PCCARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [31:0]       addr_i,
   input  logic              we_i,
   input  logic [1:0]        size_i,
   input  logic [31:0]       wdata_i,
   input  logic [BEAT_W-1:0] extra_beats_i,
   input  logic              card_mode_i,
   input  logic [1:0]        bus_width_i,
   input  logic [3:0]        wait_code_i,
   input  logic [2:0]        setup_code_i,
   input  logic [2:0]        hold_code_i,
   input  logic              wait_n_i,
   input  logic [31:0]       rdata_bus_i,
   output logic              busy_o,
   output logic              beat_o,
   output logic              done_o,
   output logic [31:0]       rdata_o,
   output logic [31:0]       addr_o,
   output logic [31:0]       wdata_o,
   output logic              cs_n_o,
   output logic              ce1_n_o,
   output logic              ce2_n_o,
   output logic              rd_n_o,
   output logic [3:0]        we_n_o,
   output logic              iord_n_o,
   output logic              iowr_n_o
);

   localparam logic [2:0] AREA_SEL = AREA_ID[2:0];

   generate
      if (AREA_ID > 7) begin : g_bad_area
         $error("AREA_ID must fit in three bits");
      end
      if (BEAT_W < 1 || BEAT_W > 8) begin : g_bad_beat
         $error("BEAT_W must be 1..8");
      end
   endgenerate

   logic              card_in, start;
   logic [31:0]       addr_q, wdata_q, rdata_q;
   logic              we_q, card_q;
   logic [1:0]        size_q, width_q;
   logic [3:0]        wcode_q;
   logic [2:0]        hold_q;
   logic [WAIT_W-1:0] waits;
   logic [3:0]        lanes;
   logic [2:0]        step;
   phase_t            phase;
   logic              beat_end, beat_more;

   generate
      if (HAS_PCCARD) begin : g_card_in
         assign card_in = card_mode_i;
      end else begin : g_no_card
         logic unused_card;
         assign unused_card = card_mode_i;
         assign card_in     = 1'b0;
      end
   endgenerate

   assign start = (phase == PH_IDLE) && req_i && (addr_i[28:26] == AREA_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         we_q    <= 1'b0;
         card_q  <= 1'b0;
         size_q  <= '0;
         width_q <= '0;
         wcode_q <= '0;
         hold_q  <= '0;
      end else if (start) begin
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
         we_q    <= we_i;
         card_q  <= card_in;
         size_q  <= size_i;
         width_q <= bus_width_i;
         wcode_q <= wait_code_i;
         hold_q  <= hold_code_i;
      end else begin
         if (beat_end)  rdata_q <= rdata_bus_i;
         if (beat_more) addr_q  <= addr_q + 32'(step);
      end
   end

   xbt_wait_map #(.HAS_PCCARD(HAS_PCCARD)) wait_map_i (
      .card  (card_q),
      .code  (wcode_q),
      .waits (waits)
   );

   xbt_lane_map lane_map_i (
      .card    (card_q),
      .width   (width_q),
      .size    (size_q),
      .addr_lo (addr_q[1:0]),
      .lanes   (lanes),
      .step    (step)
   );

   xbt_seq #(.BEAT_W(BEAT_W)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .setup_live (setup_code_i),
      .beats_live (extra_beats_i),
      .hold_code  (hold_q),
      .waits      (waits),
      .wait_n     (wait_n_i),
      .phase      (phase),
      .beat_end   (beat_end),
      .beat_more  (beat_more),
      .beat_pulse (beat_o),
      .done_pulse (done_o)
   );

   logic act, strobe, is_io;

   always_comb begin
      act      = (phase != PH_IDLE);
      strobe   = (phase == PH_STROBE);
      is_io    = card_q && addr_q[25];
      busy_o   = act;
      cs_n_o   = !(act && !card_q);
      ce1_n_o  = !(act && card_q && lanes[0]);
      ce2_n_o  = !(act && card_q && lanes[1]);
      rd_n_o   = !(strobe && !we_q && !is_io);
      iord_n_o = !(strobe && !we_q && is_io);
      iowr_n_o = !(strobe && we_q && is_io);
      if (strobe && we_q && !is_io) we_n_o = card_q ? 4'b1110 : ~lanes;
      else                          we_n_o = 4'hF;
      addr_o   = addr_q;
      wdata_o  = wdata_q;
      rdata_o  = rdata_q;
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!rd_n_o, !iord_n_o, !iowr_n_o, we_n_o != 4'hF}) <= 1) else $error("strobe clash"); // R5
   AST_SELECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!cs_n_o && !(ce1_n_o && ce2_n_o))) else $error("select clash"); // R4
   AST_STROBE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n_o || !iord_n_o || !iowr_n_o || we_n_o != 4'hF) |-> (!cs_n_o || !ce1_n_o || !ce2_n_o)) else $error("strobe unframed"); // R2
   AST_AREA_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ($past(addr_i[28:26]) == AREA_SEL)) else $error("wrong area"); // R1

endmodule

// File: tb/ext_bus_timer_tb_top.sv
module ext_bus_timer_tb_top;

   localparam int CLK_P = 10;
   localparam int SR_T[8]  = '{0, 1, 2, 3, 4, 6, 8, 10};
   localparam int PC_T[16] = '{0, 1, 2, 3, 4, 6, 8, 10, 12, 14, 18, 22, 26, 30, 34, 38};
   localparam logic [31:0] RBASE = 32'h5A00_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_i = 1'b0, we_i = 1'b0, card_mode_i = 1'b0, wait_n_i = 1'b1;
   logic [31:0] addr_i = '0, wdata_i = '0, rdata_bus_i = '0;
   logic [1:0]  size_i = '0, bus_width_i = '0, extra_beats_i = '0;
   logic [3:0]  wait_code_i = '0;
   logic [2:0]  setup_code_i = '0, hold_code_i = '0;
   logic        busy_o, beat_o, done_o, cs_n_o, ce1_n_o, ce2_n_o, rd_n_o, iord_n_o, iowr_n_o;
   logic [31:0] rdata_o, addr_o, wdata_o;
   logic [3:0]  we_n_o;

   int total = 0, bad = 0;

   always #(CLK_P/2) clk = ~clk;

   ext_bus_timer dut_i (.*);

   logic [12:0] eq_v[$];
   logic        eq_w[$];
   logic [31:0] eq_a[$], eq_d[$], eq_x[$];

   function automatic logic [3:0] lanes_of(bit card, int w, int s, logic [31:0] a);
      int ew = card ? (w > 1 ? 1 : w) : (w > 2 ? 2 : w);
      int es = (s > ew) ? ew : s;
      int nb = 1 << es;
      int off = int'(a[1:0]) % (1 << ew);
      off = off - (off % nb);
      return 4'(((1 << nb) - 1) << off);
   endfunction

   function automatic logic [12:0] vec(bit act, bit bt, bit dn, bit card, bit strb, bit we,
                                       logic [31:0] a, int w, int s);
      logic [3:0] ln = lanes_of(card, w, s, a);
      bit io = card && a[25];
      logic [3:0] wen = (strb && we && !io) ? (card ? 4'b1110 : ~ln) : 4'hF;
      return {act, bt, dn, !(act && !card), !(act && card && ln[0]), !(act && card && ln[1]),
              !(strb && !we && !io), wen, !(strb && !we && io), !(strb && we && io)};
   endfunction

   function automatic logic [12:0] outs();
      return {busy_o, beat_o, done_o, cs_n_o, ce1_n_o, ce2_n_o, rd_n_o, we_n_o, iord_n_o, iowr_n_o};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s at %0t: got=%h exp=%h", tag, $time, got, exp);
      end
   endtask

   task automatic push(logic [12:0] v, bit w, logic [31:0] a, logic [31:0] d, logic [31:0] x);
      eq_v.push_back(v); eq_w.push_back(w); eq_a.push_back(a); eq_d.push_back(d); eq_x.push_back(x);
   endtask

   task automatic idle_check(int n, string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(tag, 32'(outs()), 32'(vec(0, 0, 0, 0, 0, 0, 0, 0, 0)));
      end
   endtask

   task automatic run_txn(string tag, logic [31:0] a, bit we, int s, bit card, int w, int wc,
                          int su, int ho, int nb, int stretch, int st_beat, bit noise);
      int wt    = card ? PC_T[wc] : SR_T[wc % 8];
      int pitch = (wt + 1 < 2) ? 2 : wt + 1;
      int ew    = card ? (w > 1 ? 1 : w) : (w > 2 ? 2 : w);
      int es    = (s > ew) ? ew : s;
      logic [31:0] cur = a;
      bit nz = !noise;
      for (int i = 0; i < 2 * su + 1; i++) push(vec(1, 0, 0, card, 0, we, cur, w, s), nz, cur, 0, 0);
      for (int b = 0; b <= nb; b++) begin
         int len = (b == 0) ? 2 * (wt + 1) : 2 * pitch;
         logic [31:0] d = RBASE + 32'(b);
         for (int i = 0; i < len - 1; i++)
            push(vec(1, (b > 0 && i == 0), 0, card, 1, we, cur, w, s), nz, cur, d, d - 1);
         if (b == st_beat)
            for (int i = 0; i < stretch; i++) push(vec(1, 0, 0, card, 1, we, cur, w, s), 1'b0, cur, d, 0);
         push(vec(1, 0, 0, card, 1, we, cur, w, s), 1'b1, cur, d, 0);
         if (b < nb) cur = cur + 32'(1 << es);
      end
      for (int i = 0; i < 2 * ho + 1; i++)
         push(vec(1, (i == 0), 0, card, 0, we, cur, w, s), nz, cur, 0, RBASE + 32'(nb));
      push(vec(0, 0, 1, 0, 0, 0, 0, 0, 0), 1'b1, 0, 0, 0);

      @(negedge clk);
      req_i = 1; addr_i = a; we_i = we; size_i = 2'(s); card_mode_i = card; bus_width_i = 2'(w);
      wait_code_i = 4'(wc); setup_code_i = 3'(su); hold_code_i = 3'(ho); extra_beats_i = 2'(nb);
      wdata_i = 32'hC0FF_EE00 ^ a;
      for (int k = 0; k < eq_v.size(); k++) begin
         @(posedge clk);
         #1;
         if (k == 0) begin
            if (noise) begin  // R11: live inputs disturbed while busy
               addr_i = a + 32'h40; we_i = !we; size_i = ~size_i; card_mode_i = !card;
               bus_width_i = ~bus_width_i; wait_code_i = ~wait_code_i; setup_code_i = ~setup_code_i;
               hold_code_i = ~hold_code_i; extra_beats_i = ~extra_beats_i;
            end else req_i = 0;
         end
         if (k == eq_v.size() - 1) req_i = 0;
         wait_n_i = eq_w[k];
         rdata_bus_i = eq_d[k];
         @(negedge clk);
         chk(tag, 32'(outs()), 32'(eq_v[k]));
         if (eq_v[k][12]) chk({tag, " addr"}, addr_o, eq_a[k]);
         if (eq_v[k][11]) chk("R10 rdata", rdata_o, eq_x[k]);
         if (k == 0 && eq_v[k][12]) chk("R11 wdata", wdata_o, 32'hC0FF_EE00 ^ a);
      end
      wait_n_i = 1;
      eq_v.delete(); eq_w.delete(); eq_a.delete(); eq_d.delete(); eq_x.delete();
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      idle_check(2, "R11 reset");
      // R2 R6: memory read, long on 32-bit bus
      run_txn("R2", 32'h1800_0000, 0, 2, 0, 2, 0, 0, 0, 0, 0, -1, 0);
      idle_check(1, "R2");
      // R3: lane selection cases
      run_txn("R3 byte", 32'h1800_0002, 1, 0, 0, 2, 1, 0, 0, 0, 0, -1, 0);
      run_txn("R3 word16", 32'h1800_0003, 1, 1, 0, 1, 1, 1, 0, 0, 0, -1, 0);
      run_txn("R3 code3", 32'h1800_0002, 1, 1, 0, 3, 2, 0, 1, 0, 0, -1, 0);
      run_txn("R3 wide8", 32'h1800_0003, 1, 2, 0, 0, 0, 0, 0, 0, 0, -1, 0);
      // R6: memory wait table, bit 3 set and ignored
      for (int c = 0; c < 8; c++) run_txn("R6", 32'h1800_0000, 0, 2, 0, 2, c + 8, 1, 2, 0, 0, -1, 0);
      // R7: card wait table
      for (int c = 0; c < 16; c++) run_txn("R7", 32'h1800_0000, 0, 1, 1, 1, c, 0, 0, 0, 0, -1, 0);
      // R8: extreme setup/hold
      run_txn("R8", 32'h1800_0010, 1, 2, 0, 2, 3, 7, 7, 0, 0, -1, 0);
      // R4 R5: card memory half
      run_txn("R4 odd", 32'h1800_0001, 1, 0, 1, 1, 2, 1, 1, 0, 0, -1, 0);
      run_txn("R4 cap", 32'h1800_0004, 0, 1, 1, 2, 2, 0, 0, 0, 0, -1, 0);
      // R5: card I/O half
      run_txn("R5 iord", 32'h1A00_0002, 0, 1, 1, 1, 3, 2, 1, 0, 0, -1, 0);
      run_txn("R5 iowr", 32'h1A00_0001, 1, 0, 1, 1, 3, 1, 2, 0, 0, -1, 0);
      // R9: external stretch with wait noise elsewhere
      run_txn("R9", 32'h1800_0000, 0, 2, 0, 2, 4, 2, 1, 0, 5, 0, 1);
      // R10: bursts
      run_txn("R10 mem", 32'h1800_0100, 0, 2, 0, 2, 0, 0, 0, 3, 3, 2, 0);
      run_txn("R10 card", 32'h1800_0001, 0, 0, 1, 1, 15, 1, 1, 2, 2, 1, 1);
      run_txn("R10 pitch", 32'h1800_0200, 0, 1, 0, 2, 7, 0, 0, 1, 0, -1, 0);
      // R1: other area ignored, shadow copy accepted
      @(negedge clk);
      req_i = 1; addr_i = 32'h1400_0000;
      @(posedge clk); #1 req_i = 0;
      idle_check(4, "R1 miss");
      run_txn("R1 shadow", 32'hF800_0000, 0, 2, 0, 2, 1, 0, 0, 0, 0, -1, 0);
      idle_check(2, "R11 idle");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule